// File: doc/BRIEF.md
# Cartridge PRG/CHR Bank Mapper

This block sits between a console's CPU and PPU buses and the program and pattern ROMs of a cartridge. The CPU programs it by writing into the $8000-$FFFF window. Those writes land in a control register, sixteen 8-bit bank-number slots and a mirroring bit. From that state the block turns every CPU address into an 8 KB program-ROM bank number and every PPU pattern address into a 1 KB character-ROM bank number. It also produces the page select for the nametable memory.

Three 8 KB program windows are switchable and the top window always points at the last bank. An order bit rotates the three switchable windows. The pattern space is split into two 4 KB halves, and an inversion bit swaps the halves. One half always holds four 1 KB banks. The other half holds either two aligned 2 KB banks or, in the fine mode, four 1 KB banks that bring two extra slots into use.

An elaboration parameter selects how the nametable page is made. In one variant it comes from a register-controlled mirroring bit. In the other it comes from the top bit of the bank that is mapped at the matching 1 KB slot of PPU $0000-$0FFF. The register state is written on the rising clock edge, and all outputs are combinational from that state and the current addresses.

Top module: `cart_bank_mapper`

## Requirements
- R1: A register write happens only on a rising clock edge where `cpu_wr` is 1 and `cpu_addr[15]` is 1. `cpu_addr[14:13]` picks the register pair, and `cpu_addr[0]` picks the low (0) or high (1) register of that pair. With `cpu_wr` low, nothing changes.
- R2: A write to pair 0 low loads the control fields: data bit 7 = pattern-half inversion, bit 6 = program order, bit 5 = fine pattern mode, bits 3:0 = slot index. A write to pair 0 high stores all 8 data bits in the slot named by that index.
- R3: With order bit 0, CPU regions `cpu_addr[14:13]` = 0, 1, 2 output the low `PRG_W` bits of slots 6, 7 and 15.
- R4: With order bit 1, regions 0, 1, 2 use slots 15, 6 and 7. Region 3 always outputs all ones, which is the last bank.
- R5: The four 1 KB windows come from slots 2, 3, 4, 5 in ascending address order. They sit at PPU $1000-$1FFF when the inversion bit is 0 and at $0000-$0FFF when it is 1.
- R6: With the fine bit at 0, the other half holds two 2 KB banks from slots 0 and 1. Bit 0 of the output is replaced by `ppu_addr[10]`, so both values of a pair address the same aligned 2 KB.
- R7: With the fine bit at 1, the other half holds four 1 KB banks taken in the order slot 0, slot 8, slot 1, slot 9.
- R8: With `NT_FROM_CHR`=0, a write to pair 1 low stores data bit 0 as the mirroring bit. `nt_page` equals `ppu_addr[10]` when the bit is 0 (vertical) and `ppu_addr[11]` when it is 1 (horizontal).
- R9: With `NT_FROM_CHR`=1, `nt_page` is bit 7 of the bank that the current mode maps at PPU address `ppu_addr[11:10]`×$400. The mirroring register has no effect on it.
- R10: Writes to pair 1 high, to pairs 2 and 3, and to addresses below $8000 change no output.
- R11: Reset clears the control register, all slots and the mirroring bit to 0.
- R12: Slots 10-14 can be written, but their contents affect no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe |
| ppu_addr | input | 14 | PPU address |
| prg_bank | output | PRG_W | Program ROM address bits 17:13 |
| chr_bank | output | CHR_W | Character ROM address bits 17:10 |
| nt_page | output | 1 | Nametable page select |

## Verification
A write that changes the control register or a slot can land in the same cycle in which the PPU and CPU addresses point at the window that this change remaps. The first cycle after such a write must already show the new bank, and the cycle before it must show the old one. The bench provokes this by changing the PPU and CPU addresses at the same moment as random register writes, and it compares all outputs against a behavioural model on every clock. The model is a slot array updated at the edge, so any one-cycle lag or early update shows up as a mismatch.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;
   localparam int DATA_W    = 8;
   localparam int NUM_SLOTS = 16;
   localparam int IDX_W     = $clog2(NUM_SLOTS);

   localparam logic [1:0] PAIR_BANK   = 2'd0;
   localparam logic [1:0] PAIR_MIRROR = 2'd1;

   localparam logic [IDX_W-1:0] SLOT_PRG_A = 4'd6;
   localparam logic [IDX_W-1:0] SLOT_PRG_B = 4'd7;
   localparam logic [IDX_W-1:0] SLOT_PRG_C = 4'd15;
   localparam logic [IDX_W-1:0] SLOT_XTRA0 = 4'd8;
   localparam logic [IDX_W-1:0] SLOT_XTRA1 = 4'd9;

   typedef logic [DATA_W-1:0] slot_t;
   typedef slot_t [NUM_SLOTS-1:0] slot_arr_t;

   typedef struct packed {
      logic             chr_inv;
      logic             prg_rot;
      logic             chr_fine;
      logic [IDX_W-1:0] idx;
   } bank_ctl_t;
endpackage

// File: rtl/bm_regs.sv
module bm_regs
   import bank_mapper_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        win,
   input  logic              a0,
   input  logic [DATA_W-1:0] wdata,
   output bank_ctl_t         ctl,
   output slot_arr_t         slots,
   output logic              mirror
);
   logic hit, sel_wr, data_wr, mir_wr;
   logic unused_wbit;

   assign hit     = wr_en & win[2];
   assign sel_wr  = hit && (win[1:0] == PAIR_BANK)   && !a0;
   assign data_wr = hit && (win[1:0] == PAIR_BANK)   &&  a0;
   assign mir_wr  = hit && (win[1:0] == PAIR_MIRROR) && !a0;
   assign unused_wbit = wdata[4];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl    <= '0;
         mirror <= 1'b0;
      end else begin
         if (sel_wr) ctl <= '{chr_inv: wdata[7], prg_rot: wdata[6],
                              chr_fine: wdata[5], idx: wdata[IDX_W-1:0]};
         if (mir_wr) mirror <= wdata[0];
      end
   end

   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                  slots[g] <= '0;
         else if (data_wr && ctl.idx == IDX_W'(g))    slots[g] <= wdata;
      end
   end
endmodule

// File: rtl/bm_prg_map.sv
module bm_prg_map
   import bank_mapper_pkg::*;
#(
   parameter int PRG_W = 5
)(
   input  logic             prg_rot,
   input  slot_arr_t        slots,
   input  logic [1:0]       region,
   output logic [PRG_W-1:0] bank
);
   logic [IDX_W-1:0] pick;
   slot_t            picked;
   logic             unused_slots;

   assign unused_slots = ^slots;

   always_comb begin
      unique case (region)
         2'd0:    pick = prg_rot ? SLOT_PRG_C : SLOT_PRG_A;
         2'd1:    pick = prg_rot ? SLOT_PRG_A : SLOT_PRG_B;
         default: pick = prg_rot ? SLOT_PRG_B : SLOT_PRG_C;
      endcase
      picked = slots[pick];
      bank   = (region == 2'd3) ? '1 : picked[PRG_W-1:0];
   end
endmodule

// File: rtl/bm_chr_map.sv
module bm_chr_map
   import bank_mapper_pkg::*;
(
   input  logic       chr_inv,
   input  logic       chr_fine,
   input  slot_arr_t  slots,
   input  logic [2:0] kb_slot,
   output slot_t      bank
);
   logic [2:0] eff;
   slot_t      pair_bank;
   logic       unused_slots;

   assign unused_slots = ^slots;
   assign eff          = kb_slot ^ {chr_inv, 2'b00};

   always_comb begin
      pair_bank = slots[{3'b000, eff[1]}];
      if (eff[2]) begin
         bank = slots[{1'b0, eff} - 4'd2];
      end else if (chr_fine) begin
         unique case (eff[1:0])
            2'd0:    bank = slots[0];
            2'd1:    bank = slots[SLOT_XTRA0];
            2'd2:    bank = slots[1];
            default: bank = slots[SLOT_XTRA1];
         endcase
      end else begin
         bank = {pair_bank[DATA_W-1:1], eff[0]};
      end
   end
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
   import bank_mapper_pkg::*;
#(
   parameter int PRG_W       = 5,
   parameter int CHR_W       = 8,
   parameter int NT_FROM_CHR = 0
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [15:0]      cpu_addr,
   input  logic [7:0]       cpu_data,
   input  logic             cpu_wr,
   input  logic [13:0]      ppu_addr,
   output logic [PRG_W-1:0] prg_bank,
   output logic [CHR_W-1:0] chr_bank,
   output logic             nt_page
);
   if (PRG_W < 1 || PRG_W > DATA_W) begin : g_bad_prg
      $error("PRG_W out of range");
   end
   if (CHR_W < 1 || CHR_W > DATA_W) begin : g_bad_chr
      $error("CHR_W out of range");
   end
   if (NT_FROM_CHR != 0 && NT_FROM_CHR != 1) begin : g_bad_nt
      $error("NT_FROM_CHR must be 0 or 1");
   end

   bank_ctl_t ctl_q;
   slot_arr_t slots_q;
   logic      mirror_q;
   slot_t     pat_bank;
   logic      unused_bits;

   bm_regs u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (cpu_wr),
      .win    (cpu_addr[15:13]),
      .a0     (cpu_addr[0]),
      .wdata  (cpu_data),
      .ctl    (ctl_q),
      .slots  (slots_q),
      .mirror (mirror_q)
   );

   bm_prg_map #(.PRG_W(PRG_W)) u_prg (
      .prg_rot (ctl_q.prg_rot),
      .slots   (slots_q),
      .region  (cpu_addr[14:13]),
      .bank    (prg_bank)
   );

   bm_chr_map u_chr (
      .chr_inv  (ctl_q.chr_inv),
      .chr_fine (ctl_q.chr_fine),
      .slots    (slots_q),
      .kb_slot  (ppu_addr[12:10]),
      .bank     (pat_bank)
   );

   assign chr_bank = pat_bank[CHR_W-1:0];

   if (NT_FROM_CHR == 1) begin : g_nt_chr
      slot_t nt_bank;
      logic  unused_nt;
      bm_chr_map u_nt (
         .chr_inv  (ctl_q.chr_inv),
         .chr_fine (ctl_q.chr_fine),
         .slots    (slots_q),
         .kb_slot  ({1'b0, ppu_addr[11:10]}),
         .bank     (nt_bank)
      );
      assign nt_page   = nt_bank[DATA_W-1];
      assign unused_nt = ^{nt_bank[DATA_W-2:0], mirror_q};
   end else begin : g_nt_reg
      assign nt_page = mirror_q ? ppu_addr[11] : ppu_addr[10];
   end

   assign unused_bits = ^{cpu_addr[12:1], ppu_addr[13], ppu_addr[9:0], pat_bank};
endmodule

// File: rtl/bm_checker.sv
module bm_checker
   import bank_mapper_pkg::*;
#(
   parameter int PRG_W       = 5,
   parameter int NT_FROM_CHR = 0
)(
   input logic             clk,
   input logic             rst_n,
   input logic [15:0]      cpu_addr,
   input logic [7:0]       cpu_data,
   input logic             cpu_wr,
   input logic [13:0]      ppu_addr,
   input logic [PRG_W-1:0] prg_bank,
   input logic [7:0]       chr_low,
   input logic             nt_page,
   input bank_ctl_t        ctl,
   input logic             mirror
);
   assert_prg_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_addr[14:13] == 2'b11 |-> prg_bank == {PRG_W{1'b1}});

   assert_ctl_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_addr[15:13] == 3'b100 && !cpu_addr[0])
      |=> ctl == {$past(cpu_data[7:5]), $past(cpu_data[3:0])});

   assert_pair_alias_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl.chr_fine && (ppu_addr[12] == ctl.chr_inv)) |-> chr_low[0] == ppu_addr[10]);

   assert_upper_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_addr[15:14] == 2'b11) |=> ($stable(ctl) && $stable(mirror)));

   assert_mirror_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_addr[15:13] == 3'b101 && !cpu_addr[0]) |=> mirror == $past(cpu_data[0]));

   if (NT_FROM_CHR == 0) begin : g_reg_nt
      assert_nt_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
         nt_page == (mirror ? ppu_addr[11] : ppu_addr[10]));
   end
endmodule

bind cart_bank_mapper bm_checker #(.PRG_W(PRG_W), .NT_FROM_CHR(NT_FROM_CHR)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cpu_addr (cpu_addr),
   .cpu_data (cpu_data),
   .cpu_wr   (cpu_wr),
   .ppu_addr (ppu_addr),
   .prg_bank (prg_bank),
   .chr_low  (pat_bank),
   .nt_page  (nt_page),
   .ctl      (ctl_q),
   .mirror   (mirror_q)
);

// File: tb/sim_cart_bank_mapper.sv
module sim_cart_bank_mapper;
   logic        clk = 1'b0;
   logic        rst_n = 1'b1;
   logic [15:0] cpu_addr = 16'h0000;
   logic [7:0]  cpu_data = 8'h00;
   logic        cpu_wr = 1'b0;
   logic [13:0] ppu_addr = 14'h0000;
   logic [4:0]  prg0, prg1;
   logic [7:0]  chr0, chr1;
   logic        nt0, nt1;

   int checks = 0;
   int errors = 0;
   bit run = 0;
   bit done = 0;
   string phase = "";

   always #10 clk = ~clk;

   cart_bank_mapper #(.PRG_W(5), .CHR_W(8), .NT_FROM_CHR(0)) u0 (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
      .cpu_wr(cpu_wr), .ppu_addr(ppu_addr), .prg_bank(prg0), .chr_bank(chr0), .nt_page(nt0));

   cart_bank_mapper #(.PRG_W(5), .CHR_W(8), .NT_FROM_CHR(1)) u1 (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
      .cpu_wr(cpu_wr), .ppu_addr(ppu_addr), .prg_bank(prg1), .chr_bank(chr1), .nt_page(nt1));

   // behavioural reference state
   int m_slot [16];
   int m_inv, m_rot, m_fine, m_idx, m_mir;

   task automatic model_clear();
      for (int i = 0; i < 16; i++) m_slot[i] = 0;
      m_inv = 0; m_rot = 0; m_fine = 0; m_idx = 0; m_mir = 0;
   endtask

   initial model_clear();

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) model_clear();
      else if (cpu_wr && cpu_addr[15]) begin
         int pair;
         pair = int'(cpu_addr[14:13]);
         if (pair == 0 && !cpu_addr[0]) begin
            m_inv = cpu_data[7]; m_rot = cpu_data[6]; m_fine = cpu_data[5];
            m_idx = int'(cpu_data[3:0]);
         end else if (pair == 0) begin
            m_slot[m_idx] = int'(cpu_data);
         end else if (pair == 1 && !cpu_addr[0]) begin
            m_mir = cpu_data[0];
         end
      end
   end

   function automatic int exp_prg(int region);
      int order0 [3] = '{6, 7, 15};
      int order1 [3] = '{15, 6, 7};
      if (region == 3) return 31;
      return (m_rot ? m_slot[order1[region]] : m_slot[order0[region]]) % 32;
   endfunction

   function automatic int exp_chr(int kb);
      int e;
      int fine_order [4] = '{0, 8, 1, 9};
      e = kb ^ (m_inv ? 4 : 0);
      if (e >= 4) return m_slot[e - 2];
      if (m_fine) return m_slot[fine_order[e]];
      return (m_slot[e / 2] & 8'hFE) | (e % 2);
   endfunction

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s at %0t: actual %0h expected %0h (cpu %h ppu %h)",
                  tag, phase, $time, act, exp, cpu_addr, ppu_addr);
      end
   endtask

   // compare every clock, mid-cycle
   always @(negedge clk) begin
      if (run && !done) begin
         int region, kb;
         region = int'(cpu_addr[14:13]);
         kb = int'(ppu_addr[12:10]);
         chk((region == 3 || m_rot) ? "R4" : "R3", int'(prg0), exp_prg(region));
         chk((region == 3 || m_rot) ? "R4" : "R3", int'(prg1), exp_prg(region));
         chk(m_fine ? "R7" : (((kb >= 4) != (m_inv == 1)) ? "R5" : "R6"), int'(chr0), exp_chr(kb));
         chk("R8", int'(nt0), m_mir ? int'(ppu_addr[11]) : int'(ppu_addr[10]));
         chk("R9", int'(nt1), exp_chr(int'(ppu_addr[11:10])) / 128);
      end
   end

   task automatic wr(logic [15:0] a, logic [7:0] d, logic strobe = 1'b1);
      @(posedge clk); #5;
      cpu_addr = a; cpu_data = d; cpu_wr = strobe;
      @(posedge clk); #5;
      cpu_wr = 1'b0;
   endtask

   task automatic sweep();
      for (int r = 0; r < 4; r++) begin
         for (int k = 0; k < 16; k++) begin
            @(posedge clk); #5;
            cpu_addr = 16'h8000 | 16'(r << 13) | 16'(k * 3);
            ppu_addr = 14'(k << 10) | 14'(r * 5);
         end
      end
   endtask

   task automatic fill(int base);
      for (int i = 0; i < 16; i++) begin
         wr(16'h8000, 8'(i));
         wr(16'h8001, 8'(base + i * 37));
      end
   endtask

   initial begin
      #1 rst_n = 1'b0;
      @(posedge clk); #5 run = 1;
      phase = "R11 reset";
      sweep();
      @(posedge clk); #5 rst_n = 1'b1;
      sweep();

      phase = "R2 fill";
      fill(8'h11);
      for (int m = 0; m < 8; m++) begin
         phase = (m[1]) ? "R7 fine" : "R6 pair";
         wr(16'h8000, 8'((m[2] << 7) | (m[0] << 6) | (m[1] << 5)));
         wr(16'hA000, 8'(m % 2));
         sweep();
      end

      phase = "R1 strobe low";
      wr(16'h8000, 8'h06);
      wr(16'h8001, 8'hA5, 1'b0);
      wr(16'hA000, 8'h01, 1'b0);
      sweep();

      phase = "R10 ignored";
      wr(16'hA001, 8'hFF);
      wr(16'hC000, 8'hFF); wr(16'hC001, 8'hE0);
      wr(16'hE000, 8'hFF); wr(16'hE001, 8'hFF);
      wr(16'h0001, 8'h3C); wr(16'h6000, 8'hE1);
      sweep();

      phase = "R12 unused slots";
      for (int i = 10; i < 15; i++) begin
         wr(16'h8000, 8'(8'hE0 | i));
         wr(16'h8001, 8'h5A);
      end
      sweep();

      phase = "R9 variant";
      for (int m = 0; m < 4; m++) begin
         wr(16'h8000, 8'((m[1] << 7) | (m[0] << 5)));
         wr(16'hA000, 8'(m));
         sweep();
      end

      phase = "random";
      for (int n = 0; n < 3000; n++) begin
         logic [15:0] a;
         a = 16'($urandom);
         if ($urandom_range(0, 3) != 0) a = {1'b1, a[14:13], 12'h000, a[0]};
         @(posedge clk); #5;
         cpu_addr = a; cpu_data = 8'($urandom);
         cpu_wr = ($urandom_range(0, 1) == 1);
         ppu_addr = 14'($urandom);
      end
      @(posedge clk); #5 cpu_wr = 1'b0;
      @(posedge clk); #5;

      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule